// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

A clocked single-port SRAM model with a small internal array. It offers two address-strobe inputs with different rules, a processor-side strobe and a controller-side strobe, three chip-select inputs, a burst-advance input and a layered write decode. The write decode has a global write, a byte-write qualifier and per-lane write enables. Accesses can be single words or four-beat bursts. A burst walks the two low address bits in either linear or interleaved order and wraps after four beats.

The bidirectional data bus is modelled as three separate vectors: write data in, read data out and a per-lane driver enable. A run-time mode input picks between two read timings. In registered mode read data passes through an output register, giving 3-1-1-1 burst timing. In flow-through mode that register is bypassed, giving 2-1-1-1 timing. The output drivers follow single-cycle deselect: each read owns exactly one output slot, and a deselect or write never holds the drivers on. An output-enable input gates the drivers asynchronously.

Top module: `sburst_sram`

## Requirements
- R1: The part is selected only when `ce2`=1, `ce1_n`=0 and `ce3_n`=0. An effective strobe that sees the part unselected is a deselect cycle: no access takes place, any burst ends, and later strobe-free cycles stay idle with the drivers off. `ce2` and `ce3_n` are only looked at in strobe cycles, so a burst in progress continues whatever their values.
- R2: While `ce1_n`=1, a low `adsp_n` is ignored. With `adsc_n` high, such a cycle behaves as a burst continue or suspend.
- R3: A burst started by `adsp_n` (with the part selected) is always a read. Memory is left unchanged even when `gw_n` or `bwe_n` is low.
- R4: A burst started by `adsc_n` (with the part selected) is a write when the write decode asks for one, and a read otherwise. Data is taken from `d_in` at the same clock edge as the command.
- R5: In a cycle with no effective strobe, `adv_n`=0 advances the burst to its next beat and `adv_n`=1 repeats the current beat. The cycle reads or writes according to the write decode. For burst count c (0..3) and start address s, the low two address bits are (s[1:0]+c) mod 4 when `ilv_order`=0 and s[1:0] XOR c when `ilv_order`=1; the upper bits stay at s. The fifth beat is the start address again.
- R6: `gw_n`=0 writes all lanes. Otherwise, `bwe_n`=0 writes only the lanes i whose `lane_we_n[i]` is 0; lane i is `d_in[i*LANE_W +: LANE_W]`. With `bwe_n`=0 and no lane enabled, the cycle is a write of nothing. With both high, the cycle is a read.
- R7: A read captured at clock edge k drives its word on `d_out`, with all `d_oe` bits set together, after edge k when `reg_out`=0, and after edge k+1 when `reg_out`=1.
- R8: The output slot belonging to a write cycle has `d_oe`=0, whatever the lane enables are.
- R9: A deselect captured at edge k leaves `d_oe`=0 in its slot: after edge k+1 in registered mode, after edge k in flow-through mode. The drivers are never held on for an extra cycle after the last read.
- R10: `oe_n`=1 forces `d_oe`=0 immediately, without waiting for a clock. `oe_n`=0 enables drivers only during a read slot. Reads done with `oe_n`=1 still advance the burst.
- R11: Synchronous reset `rst` ends any burst and clears the read pipeline, so `d_oe`=0 after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ce1_n | input | 1 | Chip select, active low; also masks the processor strobe |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| addr | input | AW | Word address |
| ilv_order | input | 1 | Burst order: 1 interleaved, 0 linear |
| reg_out | input | 1 | Read timing: 1 registered, 0 flow-through |
| oe_n | input | 1 | Asynchronous output enable, active low |
| d_in | input | LANES*LANE_W | Write data |
| d_out | output | LANES*LANE_W | Read data, zero while not driving |
| d_oe | output | LANES | Per-lane driver enables |

## Verification
In flow-through mode a read's word and enable are due right after the edge that captures the command. In registered mode they are due one edge later. Writes, deselects and idle cycles leave their slot undriven on the same schedule. The bench drives each cycle's inputs at the falling edge. A behavioural model updated at the rising edge keeps the previous command's read result as the registered-mode slot and the current command's result as the flow-through slot. The outputs are compared at the next falling edge, so each result is sampled in exactly the half cycle it is due. The asynchronous output-enable gate is also probed between edges, a fraction of a cycle after `oe_n` moves.

// File: rtl/sburst_sram.sv
`timescale 1ns/1ps
module sburst_sram #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int AW     = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ce1_n,
  input  logic                      ce2,
  input  logic                      ce3_n,
  input  logic                      adsp_n,
  input  logic                      adsc_n,
  input  logic                      adv_n,
  input  logic                      gw_n,
  input  logic                      bwe_n,
  input  logic [LANES-1:0]          lane_we_n,
  input  logic [AW-1:0]             addr,
  input  logic                      ilv_order,
  input  logic                      reg_out,
  input  logic                      oe_n,
  input  logic [LANES*LANE_W-1:0]   d_in,
  output logic [LANES*LANE_W-1:0]   d_out,
  output logic [LANES-1:0]          d_oe
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic          sel, p_go, strobe, wr_req, access, do_wr, do_rd, busy, drive;
  logic [LANES-1:0] lane_mask;
  logic [AW-1:0] base, base_nx, acc, a1;
  logic [1:0]    beat, beat_nx, low;
  logic          rd1, rd2;
  logic [DW-1:0] word_now, q2;

  // command decode
  assign sel    = ce2 & ~ce1_n & ~ce3_n;
  assign p_go   = ~adsp_n & ~ce1_n;
  assign strobe = p_go | ~adsc_n;
  assign wr_req = ~gw_n | ~bwe_n;
  assign lane_mask = ~gw_n ? {LANES{1'b1}} : (~bwe_n ? ~lane_we_n : {LANES{1'b0}});
  assign access = strobe ? sel : busy;
  assign do_wr  = access & wr_req & ~p_go;
  assign do_rd  = access & ~do_wr;

  // burst address
  assign base_nx = strobe ? addr : base;
  assign beat_nx = strobe ? 2'd0 : beat + {1'b0, ~adv_n};
  assign low     = ilv_order ? (base_nx[1:0] ^ beat_nx) : (base_nx[1:0] + beat_nx);
  assign acc     = {base_nx[AW-1:2], low};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      rd1  <= 1'b0;
      rd2  <= 1'b0;
    end else begin
      busy <= access;
      rd1  <= do_rd;
      rd2  <= rd1;
    end
    base <= base_nx;
    beat <= beat_nx;
    a1   <= acc;
    q2   <= word_now;
  end

  // storage, one array per byte lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    always_ff @(posedge clk)
      if (do_wr && lane_mask[l]) cells[acc] <= d_in[l*LANE_W +: LANE_W];
    assign word_now[l*LANE_W +: LANE_W] = cells[a1];
  end

  // output slot: flow-through uses stage 1, registered uses stage 2
  assign drive = (reg_out ? rd2 : rd1) & ~oe_n;
  assign d_oe  = {LANES{drive}};
  assign d_out = drive ? (reg_out ? q2 : word_now) : {DW{1'b0}};
endmodule

// File: rtl/sburst_sram_chk.sv
`timescale 1ns/1ps
module sburst_sram_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_out,
  input logic             oe_n,
  input logic             adsp_n,
  input logic             adsc_n,
  input logic             ce1_n,
  input logic             sel,
  input logic             strobe,
  input logic             p_go,
  input logic             busy,
  input logic             do_wr,
  input logic [LANES-1:0] d_oe
);
  logic [1:0] up;
  always_ff @(posedge clk)
    if (rst) up <= 2'd0;
    else if (up != 2'd3) up <= up + 2'd1;

  p_rst_off_r11: assert property (@(posedge clk) rst |=> d_oe == '0);
  p_oe_gate_r10: assert property (@(posedge clk) disable iff (rst) oe_n |-> d_oe == '0);
  p_lanes_r7: assert property (@(posedge clk) disable iff (rst) (d_oe == '0 || d_oe == '1));
  p_p_read_r3: assert property (@(posedge clk) disable iff (rst) (p_go && sel) |-> !do_wr);
  p_e1_mask_r2: assert property (@(posedge clk) disable iff (rst)
    (!adsp_n && ce1_n && adsc_n && busy) |=> busy);
  p_desel_end_r1: assert property (@(posedge clk) disable iff (rst) (strobe && !sel) |=> !busy);
  p_desel_flow_r9: assert property (@(posedge clk) disable iff (rst)
    (up == 2'd3 && strobe && !sel && !reg_out) |=> (reg_out || d_oe == '0));
  p_desel_pipe_r9: assert property (@(posedge clk) disable iff (rst)
    (up == 2'd3 && $past(strobe && !sel && reg_out) && reg_out) |=> (!reg_out || d_oe == '0));
  p_wr_flow_r8: assert property (@(posedge clk) disable iff (rst)
    (up == 2'd3 && do_wr && !reg_out) |=> (reg_out || d_oe == '0));
  p_wr_pipe_r8: assert property (@(posedge clk) disable iff (rst)
    (up == 2'd3 && $past(do_wr && reg_out) && reg_out) |=> (!reg_out || d_oe == '0));
endmodule

bind sburst_sram sburst_sram_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .reg_out(reg_out), .oe_n(oe_n), .adsp_n(adsp_n),
  .adsc_n(adsc_n), .ce1_n(ce1_n), .sel(sel), .strobe(strobe), .p_go(p_go),
  .busy(busy), .do_wr(do_wr), .d_oe(d_oe)
);

// File: tb/sim_sburst_sram.sv
`timescale 1ns/1ps
module sim_sburst_sram;
  localparam int LANES = 4, LW = 9, AW = 6, DW = 36;

  logic clk = 0, rst = 1;
  logic ce1_n = 0, ce2 = 1, ce3_n = 0, adsp_n = 1, adsc_n = 1, adv_n = 1;
  logic gw_n = 1, bwe_n = 1, ilv = 0, regm = 1, oe_n = 0;
  logic [LANES-1:0] lane_we_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d_in = '0, d_out;
  logic [LANES-1:0] d_oe;

  always #2.5 clk = ~clk;

  sburst_sram #(.LANES(LANES), .LANE_W(LW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .lane_we_n(lane_we_n), .addr(addr), .ilv_order(ilv), .reg_out(regm),
    .oe_n(oe_n), .d_in(d_in), .d_out(d_out), .d_oe(d_oe));

  int checks = 0, fails = 0;
  string req = "R11";
  bit finished = 0;

  // behavioural reference
  logic [DW-1:0] mm [64];
  int base = 0, cnt = 0;
  bit act = 0, prv_rd = 0, exp_en = 0;
  logic [DW-1:0] prv_dat = '0, exp_dat = '0;

  initial for (int i = 0; i < 64; i++) mm[i] = '0;

  always @(posedge clk) begin : mdl
    bit en, sp, sc, wr;
    int kind, acc;
    logic [DW-1:0] cur;
    if (rst) begin
      act = 0; prv_rd = 0; exp_en = 0;
    end else begin
      en = ce2 && !ce1_n && !ce3_n;
      sp = !adsp_n && !ce1_n;
      sc = !sp && !adsc_n;
      wr = !gw_n || !bwe_n;
      kind = 0;
      if (sp || sc) begin
        if (en) begin base = int'(addr); cnt = 0; act = 1; kind = (sc && wr) ? 2 : 1; end
        else act = 0;
      end else if (act) begin
        if (!adv_n) cnt = (cnt + 1) % 4;
        kind = wr ? 2 : 1;
      end
      acc = (base / 4) * 4 + (ilv ? ((base % 4) ^ cnt) : ((base % 4 + cnt) % 4));
      cur = mm[acc];
      if (kind == 2)
        for (int l = 0; l < LANES; l++)
          if (!gw_n || !lane_we_n[l]) mm[acc][l*LW +: LW] = d_in[l*LW +: LW];
      if (regm) begin exp_en = prv_rd; exp_dat = prv_dat; end
      else begin exp_en = (kind == 1); exp_dat = cur; end
      prv_rd = (kind == 1);
      prv_dat = cur;
    end
  end

  task automatic chk(input bit ok, input string r, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  task automatic compare();
    logic [LANES-1:0] want;
    want = (exp_en && !oe_n) ? '1 : '0;
    checks++;
    if (d_oe !== want || (want != 0 && d_out !== exp_dat)) begin
      fails++;
      $display("FAIL %s: d_oe=%h d_out=%h expected d_oe=%h d_out=%h", req, d_oe, d_out, want, exp_dat);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    logic [31:0] m;
    m = 32'(a) * 32'h9E37_79B1;
    return {4'(a) ^ 4'hA, m};
  endfunction

  task automatic idle_in();
    adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; lane_we_n = '1;
    ce1_n = 0; ce2 = 1; ce3_n = 0;
  endtask
  task automatic c_wr(input int a, input logic [DW-1:0] d);
    idle_in(); adsc_n = 0; gw_n = 0; addr = AW'(a); d_in = d; step();
  endtask
  task automatic c_rd(input int a);
    idle_in(); adsc_n = 0; addr = AW'(a); step();
  endtask
  task automatic go(input bit adv);
    idle_in(); adv_n = !adv; step();
  endtask
  task automatic desel();
    idle_in(); adsc_n = 0; ce1_n = 1; step();
  endtask

  initial begin
    // R11 reset state
    repeat (3) step();
    chk(d_oe == '0, "R11", 64'(d_oe), 64'h0);
    rst = 0;

    req = "R4"; regm = 1;
    for (int a = 0; a < 64; a++) c_wr(a, pat(a));
    desel();

    req = "R7";
    c_rd(5); c_rd(9); desel(); desel();
    regm = 0;
    c_rd(12); c_rd(40); desel(); desel();

    req = "R5"; regm = 1; ilv = 0;
    c_rd(13); go(1); go(1); go(1); go(1); go(0); go(0); go(1); desel(); desel();
    regm = 0; ilv = 1;
    c_rd(22); go(1); go(1); go(1); go(1); go(0); desel();
    c_rd(25); go(1); go(1); desel();

    req = "R6"; ilv = 0;
    idle_in(); adsc_n = 0; bwe_n = 0; lane_we_n = 4'b1010; addr = 30; d_in = '1; step();
    idle_in(); adsc_n = 0; bwe_n = 0; lane_we_n = 4'b1111; addr = 31; d_in = '0; step();
    idle_in(); adsc_n = 0; bwe_n = 0; lane_we_n = 4'b0111; gw_n = 0; addr = 32; d_in = '0; step();
    c_rd(30); c_rd(31); c_rd(32); desel();

    req = "R3"; regm = 1;
    idle_in(); adsp_n = 0; gw_n = 0; addr = 33; d_in = '0; step();
    idle_in(); adsp_n = 0; bwe_n = 0; lane_we_n = '0; addr = 34; step();
    c_rd(33); c_rd(34); desel(); desel();

    req = "R2";
    c_rd(40); go(1);
    idle_in(); adsp_n = 0; ce1_n = 1; adv_n = 0; addr = 3; step();
    go(1); desel(); desel();

    req = "R1";
    idle_in(); adsc_n = 0; ce2 = 0; addr = 7; step();
    go(1); go(1);
    idle_in(); adsp_n = 0; ce3_n = 1; addr = 7; step();
    go(1); go(1);
    idle_in(); adsp_n = 0; adsc_n = 0; ce1_n = 1; addr = 7; step();
    go(1);
    c_rd(8);
    idle_in(); ce2 = 0; ce3_n = 1; adv_n = 0; step();
    go(1); desel(); desel();

    req = "R4";
    c_wr(48, 36'h1_2345_6789);
    idle_in(); gw_n = 0; adv_n = 0; d_in = 36'hF_0F0F_0F0F; step();
    idle_in(); gw_n = 0; adv_n = 0; d_in = 36'h0_F0F0_F0F0; step();
    idle_in(); gw_n = 0; adv_n = 0; d_in = 36'h5_AAAA_5555; step();
    desel(); c_rd(48); go(1); go(1); go(1); desel(); desel();

    req = "R8";
    c_rd(2); c_wr(50, 36'h3_3333_3333); c_rd(50); desel(); desel();
    regm = 0;
    c_rd(3); c_wr(51, 36'h4_4444_4444); c_rd(51); desel();

    req = "R9";
    c_rd(4); desel(); desel();
    regm = 1;
    c_rd(4); desel(); desel(); c_rd(6); c_rd(7); desel(); desel();

    req = "R10";
    oe_n = 1; c_rd(16); go(1); go(1);
    oe_n = 0; go(1); go(1); desel(); desel();
    c_rd(17); go(1);
    oe_n = 1; #1;
    chk(d_oe == '0, "R10", 64'(d_oe), 64'h0);
    oe_n = 0; #1;
    chk(d_oe == '1, "R10", 64'(d_oe), 64'hF);
    chk(d_out == pat(17), "R10", 64'(d_out), 64'(pat(17)));
    desel(); desel();

    req = "R11";
    c_rd(20); go(1);
    rst = 1; go(1);
    chk(d_oe == '0, "R11", 64'(d_oe), 64'h0);
    rst = 0; go(1); go(1);
    c_rd(21); go(1); desel(); desel();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule